// File: doc/BRIEF.md
# Segmented IR Sample Ring Buffer

This block holds the run-length samples produced by an infrared receiver. Each sample is one byte: a space/pulse marker and a duration counted in sample periods. The samples go into a ring. The ring's linear index space joins three memory segments. The first is a fixed 8-entry main area. Behind it sit two extra segments, each with a base address and a length that the host programs. An address generator turns any linear ring index into the physical byte address it occupies, so host software can fetch a sample from the right place in the memory map.

The host programs the segment setup through a small byte-wide register port, and it reads back the write pointer and an interrupt/status register through the same port. The block checks every configuration. If the segment setup is not acceptable, the block falls back to a legacy mode. In legacy mode the main area works as two ping-pong halves of `PKT_LEN` entries each, and the host is told only which half is currently being filled.

Top module: `ir_seg_ring`

## Requirements
- R1: In extended mode the ring length is 8 + LEN1 + LEN2. The write pointer advances by one on each committed sample and returns to 0 after it reaches the last index (ring length - 1).
- R2: In extended mode, index 0..7 maps to MAIN_BASE + index. Index 8..8+LEN1-1 maps to BASE1 + (index - 8). The next LEN2 indices map to BASE2 + (index - 8 - LEN1). At most one segment matches any index.
- R3: Extended mode is active only when the ring length is within 16..64 and both BASE1 and BASE2 are within 0xEC00..0xFBFC. Otherwise the block is in legacy mode. The mode is reported in status bit 1 (1 = extended).
- R4: In legacy mode the ring is 2*PKT_LEN entries (default 8), mapped to MAIN_BASE + index. The write-pointer register reads 0 while the first half is being filled and PKT_LEN while the second half is being filled.
- R5: A stored sample byte holds the space flag in bit 7 (1 = space, 0 = pulse) and the duration in bits 6:0. It is read back on `rd_data` at its ring index.
- R6: The configuration registers are: offset 0 BASE1 low byte, 1 BASE1 high byte, 2 LEN1, 3 BASE2 low byte, 4 BASE2 high byte, 5 LEN2. Each reads back what was written.
- R7: Status bit 0 is the receive interrupt flag. In extended mode it is set on every committed sample. In legacy mode it is set when a half fills. Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged, and a set in the same cycle wins.
- R8: An index at or beyond the ring length gives `rd_valid` = 0 and `rd_addr` = 0. A valid index is always below the ring length.
- R9: `ring_empty` is 1 exactly when `rd_idx` equals the write pointer.
- R10: Any write to configuration offsets 0..5 returns the write pointer to 0.
- R11: After reset the write pointer is 0, the interrupt flag is 0 and the block is in legacy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Commit one sample this cycle |
| smp_space | input | 1 | Sample is a space (1) or a pulse (0) |
| smp_dur | input | DUR_W | Sample duration in sample periods |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0..5 configuration, 6 write pointer, 7 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rd_idx | input | IDX_W | Linear ring index to look up |
| rd_valid | output | 1 | rd_idx lies inside the ring |
| rd_addr | output | ADDR_W | Physical byte address of rd_idx, 0 when invalid |
| rd_data | output | DUR_W+1 | Stored sample at rd_idx, 0 when invalid |
| ring_empty | output | 1 | rd_idx equals the write pointer |
| irq | output | 1 | Receive interrupt flag |

## Verification
The assertions assume that the mode changes only together with a configuration write. This holds because the mode is computed from the configuration registers alone. They also assume that the receiver never commits a sample in the same cycle that a configuration write moves the pointer. The bench keeps to both by driving sample commits and register writes in separate cycles. It also writes a complete six-register setup before it checks any extended-mode mapping. Lookup indices stay within the index width, so the invalid range is reached only through ring lengths shorter than 64.

// File: rtl/ir_seg_ring_pkg.sv
package ir_seg_ring_pkg;
   localparam int unsigned MAIN_LEN = 8;
   localparam int unsigned LEN_W    = 8;

   typedef enum logic [2:0] {
      RG_B1_LO = 3'd0,
      RG_B1_HI = 3'd1,
      RG_LEN1  = 3'd2,
      RG_B2_LO = 3'd3,
      RG_B2_HI = 3'd4,
      RG_LEN2  = 3'd5,
      RG_WPTR  = 3'd6,
      RG_STAT  = 3'd7
   } reg_sel_e;

   localparam int unsigned ST_IRQ = 0;
   localparam int unsigned ST_EXT = 1;
endpackage

// File: rtl/ir_seg_cfg.sv
module ir_seg_cfg
   import ir_seg_ring_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned MIN_RING = 16,
   parameter int unsigned MAX_RING = 64,
   parameter logic [15:0] BASE_LO  = 16'hEC00,
   parameter logic [15:0] BASE_HI  = 16'hFBFC,
   parameter int unsigned TOT_W    = LEN_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [ADDR_W-1:0] base1,
   output logic [ADDR_W-1:0] base2,
   output logic [LEN_W-1:0]  len1,
   output logic [LEN_W-1:0]  len2,
   output logic [TOT_W-1:0]  total_ext,
   output logic              ext_mode,
   output logic              cfg_wr
);
   localparam int unsigned NREG = 6;

   logic [NREG-1:0][7:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (reg_we) begin
         for (int i = 0; i < NREG; i++) begin
            if (reg_addr == 3'(i)) cfg_q[i] <= reg_wdata;
         end
      end
   end

   assign base1 = {cfg_q[RG_B1_HI], cfg_q[RG_B1_LO]};
   assign base2 = {cfg_q[RG_B2_HI], cfg_q[RG_B2_LO]};
   assign len1  = cfg_q[RG_LEN1];
   assign len2  = cfg_q[RG_LEN2];
   assign total_ext = TOT_W'(MAIN_LEN) + TOT_W'(len1) + TOT_W'(len2);
   assign cfg_wr = reg_we && (reg_addr <= RG_LEN2);

   logic len_ok, b1_ok, b2_ok;
   assign len_ok = (total_ext >= TOT_W'(MIN_RING)) && (total_ext <= TOT_W'(MAX_RING));
   assign b1_ok  = (base1 >= BASE_LO) && (base1 <= BASE_HI);
   assign b2_ok  = (base2 >= BASE_LO) && (base2 <= BASE_HI);
   assign ext_mode = len_ok && b1_ok && b2_ok;

   AST_MODE_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(ext_mode)) else $error("mode moved without cfg write"); // R3
endmodule

// File: rtl/ir_seg_wptr.sv
module ir_seg_wptr #(
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned TOT_W   = 10,
   parameter int unsigned PKT_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             ext_mode,
   input  logic [TOT_W-1:0] total_ext,
   input  logic             cfg_wr,
   input  logic             irq_clr,
   output logic [IDX_W-1:0] wptr,
   output logic [IDX_W-1:0] wptr_view,
   output logic [TOT_W-1:0] total,
   output logic             irq
);
   localparam logic [TOT_W-1:0] LEG_TOTAL = TOT_W'(2 * PKT_LEN);

   logic [TOT_W-1:0] nxt;
   logic             half_done, irq_set;

   assign total = ext_mode ? total_ext : LEG_TOTAL;
   assign nxt   = TOT_W'(wptr) + TOT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wptr <= '0;
      else if (cfg_wr)  wptr <= '0;
      else if (commit)  wptr <= (nxt >= total) ? '0 : IDX_W'(nxt);
   end

   assign half_done = commit && !ext_mode &&
                      ((nxt == TOT_W'(PKT_LEN)) || (nxt == LEG_TOTAL));
   assign irq_set   = commit && (ext_mode || half_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq <= 1'b0;
      else if (irq_set)  irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
   end

   assign wptr_view = ext_mode ? wptr :
                      ((wptr >= IDX_W'(PKT_LEN)) ? IDX_W'(PKT_LEN) : '0);

   AST_WPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      TOT_W'(wptr) < total) else $error("write pointer past ring end"); // R1
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !cfg_wr) |=> (wptr == '0) || (wptr == $past(wptr) + IDX_W'(1)))
      else $error("write pointer jumped"); // R1
   AST_CFG_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (wptr == '0)) else $error("cfg write kept pointer"); // R10
   AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && ext_mode) |=> irq) else $error("commit did not raise irq"); // R7
   AST_LEGACY_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (wptr_view == '0) || (wptr_view == IDX_W'(PKT_LEN)))
      else $error("legacy pointer view not a half base"); // R4
endmodule

// File: rtl/ir_seg_map.sv
module ir_seg_map
   import ir_seg_ring_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned TOT_W     = 10,
   parameter int unsigned PKT_LEN   = 4,
   parameter logic [15:0] MAIN_BASE = 16'hF8E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              ext_mode,
   input  logic [TOT_W-1:0]  total,
   input  logic [ADDR_W-1:0] base1,
   input  logic [ADDR_W-1:0] base2,
   input  logic [LEN_W-1:0]  len1,
   input  logic [LEN_W-1:0]  len2,
   output logic              valid,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned NSEG = 3;

   logic [TOT_W-1:0]  seg_start [NSEG];
   logic [TOT_W-1:0]  seg_len   [NSEG];
   logic [ADDR_W-1:0] seg_base  [NSEG];
   logic [ADDR_W-1:0] phys      [NSEG];
   logic [NSEG-1:0]   hit;
   logic [TOT_W-1:0]  idx_x;

   assign idx_x = TOT_W'(idx);

   always_comb begin
      seg_start[0] = '0;
      seg_len[0]   = ext_mode ? TOT_W'(MAIN_LEN) : TOT_W'(2 * PKT_LEN);
      seg_base[0]  = ADDR_W'(MAIN_BASE);
      seg_start[1] = TOT_W'(MAIN_LEN);
      seg_len[1]   = ext_mode ? TOT_W'(len1) : '0;
      seg_base[1]  = base1;
      seg_start[2] = TOT_W'(MAIN_LEN) + TOT_W'(len1);
      seg_len[2]   = ext_mode ? TOT_W'(len2) : '0;
      seg_base[2]  = base2;
   end

   for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
      logic [TOT_W-1:0] off;
      assign off      = idx_x - seg_start[gi];
      assign hit[gi]  = (idx_x >= seg_start[gi]) && (off < seg_len[gi]);
      assign phys[gi] = seg_base[gi] + ADDR_W'(off);
   end

   always_comb begin
      addr  = '0;
      valid = 1'b0;
      for (int i = 0; i < NSEG; i++) begin
         if (hit[i]) begin
            addr  = addr | phys[i];
            valid = 1'b1;
         end
      end
   end

   AST_ONE_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("index hit two segments"); // R2
   AST_VALID_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (idx_x < total)) else $error("valid index past ring end"); // R8
endmodule

// File: rtl/ir_seg_ring.sv
module ir_seg_ring
   import ir_seg_ring_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DUR_W     = 7,
   parameter int unsigned MAX_RING  = 64,
   parameter int unsigned MIN_RING  = 16,
   parameter int unsigned PKT_LEN   = 4,
   parameter logic [15:0] MAIN_BASE = 16'hF8E0,
   parameter logic [15:0] BASE_LO   = 16'hEC00,
   parameter logic [15:0] BASE_HI   = 16'hFBFC,
   parameter int unsigned IDX_W     = $clog2(MAX_RING)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic              smp_space,
   input  logic [DUR_W-1:0]  smp_dur,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DUR_W:0]    rd_data,
   output logic              ring_empty,
   output logic              irq
);
   localparam int unsigned TOT_W = LEN_W + 2;
   localparam int unsigned SMP_W = DUR_W + 1;

   if (ADDR_W != 16) begin : g_chk_addr
      $error("ADDR_W must be 16: bases are two byte registers");
   end
   if (2 * PKT_LEN > MAIN_LEN) begin : g_chk_pkt
      $error("legacy halves must fit in the main area");
   end
   if (MIN_RING <= MAIN_LEN || MIN_RING > MAX_RING) begin : g_chk_ring
      $error("ring length bounds inconsistent");
   end
   if (SMP_W > 8) begin : g_chk_smp
      $error("sample must fit in one byte");
   end

   logic [ADDR_W-1:0] base1, base2;
   logic [LEN_W-1:0]  len1, len2;
   logic [TOT_W-1:0]  total_ext, total;
   logic              ext_mode, cfg_wr, irq_clr;
   logic [IDX_W-1:0]  wptr, wptr_view;
   logic [SMP_W-1:0]  mem [MAX_RING];

   assign irq_clr = reg_we && (reg_addr == RG_STAT) && !reg_wdata[ST_IRQ];

   ir_seg_cfg #(
      .ADDR_W(ADDR_W), .MIN_RING(MIN_RING), .MAX_RING(MAX_RING),
      .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .TOT_W(TOT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .base1(base1), .base2(base2), .len1(len1),
      .len2(len2), .total_ext(total_ext), .ext_mode(ext_mode), .cfg_wr(cfg_wr)
   );

   ir_seg_wptr #(
      .IDX_W(IDX_W), .TOT_W(TOT_W), .PKT_LEN(PKT_LEN)
   ) u_wptr (
      .clk(clk), .rst_n(rst_n), .commit(smp_valid), .ext_mode(ext_mode),
      .total_ext(total_ext), .cfg_wr(cfg_wr), .irq_clr(irq_clr),
      .wptr(wptr), .wptr_view(wptr_view), .total(total), .irq(irq)
   );

   ir_seg_map #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TOT_W(TOT_W), .PKT_LEN(PKT_LEN),
      .MAIN_BASE(MAIN_BASE)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .idx(rd_idx), .ext_mode(ext_mode),
      .total(total), .base1(base1), .base2(base2), .len1(len1), .len2(len2),
      .valid(rd_valid), .addr(rd_addr)
   );

   always_ff @(posedge clk) begin
      if (smp_valid) mem[wptr] <= {smp_space, smp_dur};
   end

   assign rd_data    = rd_valid ? mem[rd_idx] : '0;
   assign ring_empty = (rd_idx == wptr);

   always_comb begin
      case (reg_addr)
         RG_B1_LO: reg_rdata = base1[7:0];
         RG_B1_HI: reg_rdata = base1[15:8];
         RG_LEN1:  reg_rdata = len1;
         RG_B2_LO: reg_rdata = base2[7:0];
         RG_B2_HI: reg_rdata = base2[15:8];
         RG_LEN2:  reg_rdata = len2;
         RG_WPTR:  reg_rdata = 8'(wptr_view);
         default:  reg_rdata = {6'd0, ext_mode, irq};
      endcase
   end

   AST_NO_WRITE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (TOT_W'(wptr) < total)) else $error("write outside ring"); // R8
endmodule

// File: tb/ir_seg_ring_tb.sv
module ir_seg_ring_tb;
   localparam logic [15:0] MAIN = 16'hF8E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0, smp_space = 1'b0;
   logic [6:0]  smp_dur = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0, reg_rdata;
   logic [5:0]  rd_idx = '0;
   logic        rd_valid, ring_empty, irq;
   logic [15:0] rd_addr;
   logic [7:0]  rd_data;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   ir_seg_ring u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_space(smp_space),
      .smp_dur(smp_dur), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_idx(rd_idx),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
      .ring_empty(ring_empty), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic push(logic sp, logic [6:0] d);
      @(negedge clk);
      smp_valid = 1'b1; smp_space = sp; smp_dur = d;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic look(logic [5:0] i);
      rd_idx = i;
      #1;
   endtask

   task automatic set_cfg(logic [15:0] b1, logic [7:0] l1, logic [15:0] b2, logic [7:0] l2);
      wr(3'd0, b1[7:0]); wr(3'd1, b1[15:8]); wr(3'd2, l1);
      wr(3'd3, b2[7:0]); wr(3'd4, b2[15:8]); wr(3'd5, l2);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(3'd6, v); chk("R11 wptr after reset", v, 0);
      rd(3'd7, v); chk("R11 status after reset", v, 0);
      look(6'd0);  chk("R9 empty after reset", ring_empty, 1);
   endtask

   task automatic t_legacy();
      logic [7:0] v;
      for (int k = 0; k < 3; k++) push(1'b0, 7'(k + 1));
      rd(3'd6, v); chk("R4 first half view", v, 0);
      chk("R7 no irq before half full", irq, 0);
      push(1'b1, 7'd9);
      rd(3'd6, v); chk("R4 second half view", v, 4);
      chk("R7 irq on half full", irq, 1);
      wr(3'd7, 8'h01); chk("R7 write one keeps irq", irq, 1);
      wr(3'd7, 8'h00); chk("R7 write zero clears irq", irq, 0);
      for (int k = 0; k < 4; k++) push(1'b0, 7'd2);
      rd(3'd6, v); chk("R4 wrap to first half", v, 0);
      chk("R7 irq on second half full", irq, 1);
      look(6'd5); chk("R4 legacy map", rd_addr, MAIN + 16'd5);
      look(6'd8); chk("R8 legacy beyond valid", rd_valid, 0);
      chk("R8 legacy beyond addr", rd_addr, 0);
   endtask

   task automatic t_cfg();
      logic [7:0] v;
      set_cfg(16'hEC00, 8'd4, 16'hF000, 8'd6);
      rd(3'd0, v); chk("R6 reg0", v, 8'h00);
      rd(3'd1, v); chk("R6 reg1", v, 8'hEC);
      rd(3'd2, v); chk("R6 reg2", v, 8'h04);
      rd(3'd3, v); chk("R6 reg3", v, 8'h00);
      rd(3'd4, v); chk("R6 reg4", v, 8'hF0);
      rd(3'd5, v); chk("R6 reg5", v, 8'h06);
      rd(3'd7, v); chk("R3 extended mode on", v[1], 1);
      rd(3'd6, v); chk("R10 pointer zero after setup", v, 0);
   endtask

   task automatic t_map();
      look(6'd0);  chk("R2 idx0", rd_addr, MAIN);
      look(6'd7);  chk("R2 idx7", rd_addr, MAIN + 16'd7);
      look(6'd9);  chk("R2 idx9 seg1", rd_addr, 16'hEC01);
      look(6'd12); chk("R2 idx12 seg2", rd_addr, 16'hF000);
      look(6'd17); chk("R2 idx17 seg2 end", rd_addr, 16'hF005);
      chk("R2 idx17 valid", rd_valid, 1);
      look(6'd18); chk("R8 idx18 invalid", rd_valid, 0);
      chk("R8 idx18 addr", rd_addr, 0);
   endtask

   task automatic t_wrap();
      logic [7:0] v;
      wr(3'd7, 8'h00);
      for (int k = 0; k < 17; k++) push(k[0], 7'(k + 3));
      rd(3'd6, v); chk("R1 pointer at 17", v, 17);
      chk("R7 irq in extended", irq, 1);
      look(6'd5); chk("R5 space sample", rd_data, 8'h88);
      look(6'd4); chk("R5 pulse sample", rd_data, 8'h07);
      push(1'b0, 7'd1);
      rd(3'd6, v); chk("R1 wrap to zero", v, 0);
      look(6'd0); chk("R9 empty at pointer", ring_empty, 1);
      look(6'd3); chk("R9 not empty elsewhere", ring_empty, 0);
   endtask

   task automatic t_cfg_reset();
      logic [7:0] v;
      for (int k = 0; k < 3; k++) push(1'b0, 7'd5);
      rd(3'd6, v); chk("R1 pointer at 3", v, 3);
      wr(3'd5, 8'd6);
      rd(3'd6, v); chk("R10 cfg write resets pointer", v, 0);
   endtask

   task automatic t_invalid();
      logic [7:0] v;
      set_cfg(16'hEC00, 8'd3, 16'hF000, 8'd4);
      rd(3'd7, v); chk("R3 total 15 legacy", v[1], 0);
      set_cfg(16'hEC00, 8'd28, 16'hF000, 8'd28);
      rd(3'd7, v); chk("R3 total 64 extended", v[1], 1);
      set_cfg(16'hEC00, 8'd28, 16'hF000, 8'd29);
      rd(3'd7, v); chk("R3 total 65 legacy", v[1], 0);
      set_cfg(16'hEBFF, 8'd4, 16'hF000, 8'd6);
      rd(3'd7, v); chk("R3 base1 low legacy", v[1], 0);
      set_cfg(16'hEC00, 8'd4, 16'hFBFC, 8'd6);
      rd(3'd7, v); chk("R3 base2 top extended", v[1], 1);
      set_cfg(16'hEC00, 8'd4, 16'hFBFD, 8'd6);
      rd(3'd7, v); chk("R3 base2 over legacy", v[1], 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_legacy();
      t_cfg();
      t_map();
      t_wrap();
      t_cfg_reset();
      t_invalid();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule